// File: doc/BRIEF.md
# Soft-Mute Fade Controller

This block turns a mute request into a gradual change of attenuation for a downstream gain stage. It does not switch the gain abruptly. The output `atten_db` is the attenuation in whole dB, given as a positive number: 0 means no attenuation, and the parameter `MUTE_CODE` means full mute. The value moves one dB at a time. Each step waits for a tick from an internal divider, and a slope-select input sets the divider period to either a short or a long value.

A mute can be requested in two ways, and either one is enough. The first is a control-register bit, `ctl_unmute`. Writing 0 to it asks for mute and writing 1 releases the mute. The second is an external pin, `mute_req_n`, which is active low and is high when idle. The pin passes through a synchronizer before it is used. The flag `mute_active` shows whether soft mute is in effect, so software can read that state back.

With default parameters and a 1 MHz clock, the fast slope takes 1 ms to fall from 0 dB to -20 dB and the slow slope takes 30 ms.

Top module: `softmute_ramp`

## Requirements
- R1: A 0 on `ctl_unmute` requests mute. The effective request register takes this value at the next rising clock edge.
- R2: `mute_req_n` low requests mute whatever `ctl_unmute` holds. The effective request is the OR of both sources, so mute stays requested as long as either source asks for it.
- R3: With `slope_fast`=1, `atten_db` changes by one dB every `FAST_DIV` cycles. Starting from rest, the first step comes `FAST_DIV` cycles after the request register changes.
- R4: With `slope_fast`=0, the step period is `SLOW_DIV` cycles. The first-step timing is the same as in R3.
- R5: While mute is requested, `atten_db` rises to `MUTE_CODE` and stays there. It never goes above `MUTE_CODE`.
- R6: When the request is withdrawn, `atten_db` falls back to 0 at the selected slope and then stays at 0.
- R7: If the request changes partway through a ramp, the ramp reverses from the current level without any jump. No cycle changes `atten_db` by more than 1. The step counter keeps its count through the reversal.
- R8: `mute_active` is high while the request register is set or `atten_db` is nonzero. Otherwise it is low.
- R9: After reset, `atten_db` is 0 and `mute_active` is low.
- R10: A change on the pin reaches the request register after `SYNC_STAGES`+1 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_unmute | input | 1 | Register bit: 0 requests mute, 1 releases it |
| slope_fast | input | 1 | Register bit: 1 selects the fast slope, 0 the slow slope |
| mute_req_n | input | 1 | External mute request, active low |
| atten_db | output | ATT_W | Attenuation in dB; `MUTE_CODE` means full mute |
| mute_active | output | 1 | Soft mute is in effect (high = active) |

## Verification
Latency counts from the edge at which the request register changes:
- A register-bit request sets that register on the next edge.
- A pin request sets it after `SYNC_STAGES`+1 edges.
- `mute_active` follows the request register in the same cycle.

From rest, dB step k lands exactly k·DIV edges after the request register changes. After a reversal partway through a ramp, the first step in the new direction comes one cycle early, because the step counter keeps its count.

The bench drives its inputs on falling edges and counts whole clock periods from the drive. It samples on falling edges at exactly the due edge, and also one edge before it, so that both late and early steps are caught.

// File: rtl/softmute_pkg.sv
package softmute_pkg;

   typedef enum logic [1:0] {
      RAMP_HOLD    = 2'd0,
      RAMP_DEEPER  = 2'd1,
      RAMP_LIGHTER = 2'd2
   } ramp_dir_t;

endpackage

// File: rtl/softmute_req_sync.sv
module softmute_req_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_unmute,
   input  logic mute_req_n,
   output logic req_q
);

   logic pin_n_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_n_s = mute_req_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], mute_req_n} & {SYNC_STAGES{1'b1}};
         end
         assign pin_n_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= !ctl_unmute || !pin_n_s;
   end

endmodule

// File: rtl/softmute_tick_div.sv
module softmute_tick_div #(
   parameter int FAST_DIV = 50,
   parameter int SLOW_DIV = 1500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic sel_fast,
   output logic tick
);

   localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
   localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   generate
      if (FAST_DIV == SLOW_DIV) begin : g_one_rate
         assign lim = CNT_W'(FAST_DIV - 1);
      end else begin : g_two_rate
         assign lim = sel_fast ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
      end
   endgenerate

   assign tick = run && (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/softmute_level.sv
module softmute_level
   import softmute_pkg::*;
#(
   parameter int ATT_W     = 7,
   parameter int MUTE_CODE = 80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             to_mute,
   input  logic             tick,
   output logic             run,
   output logic [ATT_W-1:0] level
);

   localparam logic [ATT_W-1:0] FULL = ATT_W'(MUTE_CODE);

   ramp_dir_t dir;

   always_comb begin
      dir = RAMP_HOLD;
      if (to_mute && level != FULL)            dir = RAMP_DEEPER;
      else if (!to_mute && level != '0)        dir = RAMP_LIGHTER;
   end

   assign run = (dir != RAMP_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
      end else if (tick) begin
         case (dir)
            RAMP_DEEPER:  level <= level + 1'b1;
            RAMP_LIGHTER: level <= level - 1'b1;
            default:      level <= level;
         endcase
      end
   end

endmodule

// File: rtl/softmute_ramp.sv
module softmute_ramp #(
   parameter int ATT_W       = 7,
   parameter int MUTE_CODE   = 80,
   parameter int FAST_DIV    = 50,
   parameter int SLOW_DIV    = 1500,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_unmute,
   input  logic             slope_fast,
   input  logic             mute_req_n,
   output logic [ATT_W-1:0] atten_db,
   output logic             mute_active
);

   generate
      if (MUTE_CODE < 1 || MUTE_CODE >= (1 << ATT_W)) begin : g_bad_code
         $error("MUTE_CODE must be in 1 .. 2**ATT_W-1");
      end
      if (FAST_DIV < 1 || SLOW_DIV < 1) begin : g_bad_div
         $error("divider periods must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be in 0 .. 4");
      end
   endgenerate

   logic req_q;
   logic run;
   logic tick;

   softmute_req_sync #(.SYNC_STAGES(SYNC_STAGES)) u_req (
      .clk(clk), .rst_n(rst_n), .ctl_unmute(ctl_unmute),
      .mute_req_n(mute_req_n), .req_q(req_q)
   );

   softmute_tick_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .sel_fast(slope_fast), .tick(tick)
   );

   softmute_level #(.ATT_W(ATT_W), .MUTE_CODE(MUTE_CODE)) u_lvl (
      .clk(clk), .rst_n(rst_n), .to_mute(req_q), .tick(tick),
      .run(run), .level(atten_db)
   );

   assign mute_active = req_q || (atten_db != '0);

endmodule

// File: rtl/softmute_ramp_chk.sv
module softmute_ramp_chk #(
   parameter int ATT_W     = 7,
   parameter int MUTE_CODE = 80
) (
   input logic             clk,
   input logic             rst_n,
   input logic [ATT_W-1:0] atten_db,
   input logic             mute_active
);

   // R7
   unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (atten_db != $past(atten_db)) |->
      ((ATT_W'(atten_db - $past(atten_db)) == ATT_W'(1)) ||
       (ATT_W'($past(atten_db) - atten_db) == ATT_W'(1))));

   // R5
   mute_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      atten_db <= ATT_W'(MUTE_CODE));

   // R8
   status_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (atten_db != '0) |-> mute_active);

   // R1
   deepen_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (atten_db > $past(atten_db)) |-> $past(mute_active));

endmodule

bind softmute_ramp softmute_ramp_chk #(.ATT_W(ATT_W), .MUTE_CODE(MUTE_CODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .atten_db(atten_db), .mute_active(mute_active)
);

// File: tb/softmute_ramp_test.sv
module softmute_ramp_test;

   localparam int CLK_PERIOD = 10;
   localparam int ATT_W = 7;
   localparam int MC    = 80;
   localparam int FD    = 4;
   localparam int SD    = 12;
   localparam int SS    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_unmute = 1'b1;
   logic slope_fast = 1'b1;
   logic mute_req_n = 1'b1;
   logic [ATT_W-1:0] atten_db;
   logic mute_active;

   int total = 0;
   int bad = 0;

   softmute_ramp #(.ATT_W(ATT_W), .MUTE_CODE(MC), .FAST_DIV(FD),
                   .SLOW_DIV(SD), .SYNC_STAGES(SS)) uut (
      .clk(clk), .rst_n(rst_n), .ctl_unmute(ctl_unmute), .slope_fast(slope_fast),
      .mute_req_n(mute_req_n), .atten_db(atten_db), .mute_active(mute_active)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      edges(2);
      check("R9 atten", atten_db, 0);
      check("R9 status", mute_active, 0);
      rst_n = 1'b1;
      edges(3);
      check("R9 idle atten", atten_db, 0);
      check("R9 idle status", mute_active, 0);
   endtask

   task automatic t_reg_fast;
      slope_fast = 1'b1;
      ctl_unmute = 1'b0;
      edges(1);
      check("R1 status", mute_active, 1);
      edges(FD - 1);
      check("R3 before step", atten_db, 0);
      edges(1);
      check("R3 first step", atten_db, 1);
      edges(19 * FD);
      check("R3 20dB", atten_db, 20);
      edges(60 * FD);
      check("R5 full", atten_db, MC);
      edges(5 * FD);
      check("R5 hold", atten_db, MC);
      ctl_unmute = 1'b1;
      edges(1 + FD - 1);
      check("R6 before down", atten_db, MC);
      edges(1);
      check("R6 first down", atten_db, MC - 1);
      edges((MC - 1) * FD - 1);
      check("R8 still active", mute_active, 1);
      edges(1);
      check("R6 back to 0", atten_db, 0);
      check("R8 status off", mute_active, 0);
      edges(3 * FD);
      check("R6 stays 0", atten_db, 0);
   endtask

   task automatic t_slow;
      slope_fast = 1'b0;
      ctl_unmute = 1'b0;
      edges(1 + SD - 1);
      check("R4 before step", atten_db, 0);
      edges(1);
      check("R4 first step", atten_db, 1);
      edges(19 * SD);
      check("R4 20dB", atten_db, 20);
      ctl_unmute = 1'b1;
      edges(1 + 21 * SD);
      check("R6 slow return", atten_db, 0);
      check("R8 slow off", mute_active, 0);
      slope_fast = 1'b1;
   endtask

   task automatic t_pin_or;
      mute_req_n = 1'b0;
      edges(SS);
      check("R10 not yet", mute_active, 0);
      edges(1);
      check("R10 pin seen", mute_active, 1);
      edges(FD);
      check("R2 pin step", atten_db, 1);
      ctl_unmute = 1'b0;
      edges(2);
      mute_req_n = 1'b1;
      edges(MC * FD);
      check("R2 OR full", atten_db, MC);
      check("R2 OR status", mute_active, 1);
      ctl_unmute = 1'b1;
      edges(1 + MC * FD);
      check("R2 release", atten_db, 0);
   endtask

   task automatic t_reverse;
      int prev;
      int rose;
      ctl_unmute = 1'b0;
      edges(1 + 10 * FD);
      check("R7 up to 10", atten_db, 10);
      ctl_unmute = 1'b1;
      edges(1);
      check("R7 no jump", atten_db, 10);
      edges(5 * FD - 1);
      check("R7 mid reverse", atten_db, 5);
      prev = atten_db;
      rose = 0;
      for (int i = 0; i < 5 * FD; i++) begin
         edges(1);
         if (atten_db > prev) rose = 1;
         prev = atten_db;
      end
      check("R7 monotone", rose, 0);
      check("R7 reached 0", atten_db, 0);
      check("R8 reverse off", mute_active, 0);
   endtask

   initial begin
      t_reset();
      t_reg_fast();
      t_slow();
      t_pin_or();
      t_reverse();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule